// File: doc/BRIEF.md
# Reset Sequencer with Stabilization Counter

This block sequences system reset for a small microcontroller. It takes a power-on reset, a supply-low indication, a watchdog reset request and the level on the bidirectional reset pad. From these it produces a drive-low enable for the open-drain pad, a CPU reset, a bus clock enable and a watchdog tick. The watchdog tick comes from a free-running prescale counter. A four-bit cause register records which source caused the most recent reset.

An internal reset is one from power-on, a qualified supply-low condition or the watchdog. On an internal reset the block clears the prescale counter and pulls the pad low while the counter counts out a hold period. After the hold, the block waits a short tail period and then lets the CPU run. An external reset is a low level driven onto the pad by someone else. It holds the CPU in reset and leaves the prescale counter untouched. The whole block, counter included, advances on the falling edge of the oscillator clock.

Top module: `rst_seq_top`

## Requirements
- R1: While `rst_ni` is low, the pad is driven low, the CPU is held in reset, bus clocks are disabled, and the cause register reads 4'b0001. Bit 0 is the power-on flag.
- R2: After an internal reset, the pad drive stays asserted for exactly HOLD_CYC clock cycles, counted from the first cycle the counter reads zero.
- R3: `cpu_rst_no` rises exactly TAIL_CYC cycles after the pad drive is released.
- R4: A supply-low indication starts a reset only after it has been high for LVD_QUAL consecutive cycles. A run of LVD_QUAL-1 cycles changes no output and does not change the cause register.
- R5: A qualified supply-low reset leaves the cause register at 4'b0100, so bit 2 is the only flag set.
- R6: A watchdog reset request starts an internal reset, drives the pad, and leaves the cause register at 4'b1000, so bit 3 is the only flag set.
- R7: A low on the pad that the block is not driving holds the CPU in reset and does not drive the pad. Its cause is 4'b0010, so bit 1 is set. It does not disturb the prescale counter.
- R8: The prescale counter is CNT_W bits wide. It pulses `wdog_tick_o` high for one cycle each time it wraps, which is once every 2^CNT_W cycles.
- R9: `bus_clk_en_o` goes high when the first hold after power-on completes. Later resets do not clear it.
- R10: An internal source that fires during the hold or tail restarts the hold from the beginning, with the counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock; the block acts on its falling edge |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| lvd_i | input | 1 | Supply-low indication, active high |
| wdog_rst_i | input | 1 | Watchdog reset request, synchronous |
| pin_rst_ni | input | 1 | Level seen on the reset pad |
| pin_rst_drive_o | output | 1 | Pulls the open-drain reset pad low |
| cpu_rst_no | output | 1 | CPU reset, active low |
| bus_clk_en_o | output | 1 | Enables the bus clocks |
| wdog_tick_o | output | 1 | One-cycle pulse on each counter wrap |
| rst_cause_o | output | 4 | Reset cause flags {watchdog, supply-low, pad, power-on} |

## Verification
The bench builds the block with CNT_W=6, HOLD_CYC=16, TAIL_CYC=4 and LVD_QUAL=9. With these values the counter wraps every 64 cycles, so the tick spacing can be measured across an external pad reset in a short run. Every hold and tail can be counted sample by sample. The supply-low filter keeps its full nine-cycle threshold, so the eight-cycle and nine-cycle boundary is tested exactly. A watchdog request is injected inside the hold and inside the tail to show that the hold restarts at full length.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_TAIL = 2'd1,
    ST_RUN  = 2'd2,
    ST_PIN  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic wdog;
    logic lvd;
    logic pin;
    logic por;
  } rst_cause_t;
endpackage

// File: rtl/rst_prescaler.sv
module rst_prescaler #(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
      tick_q <= &cnt_q;
    end
  end

  assign cnt_o  = cnt_q;
  assign tick_o = tick_q;

  p_tick_on_wrap_r8: assert property (@(negedge clk_i) disable iff (!rst_ni)
    tick_q |-> (cnt_q == '0));
endmodule

// File: rtl/rst_lvd_filter.sv
module rst_lvd_filter #(
  parameter int LVD_QUAL = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvd_i,
  output logic qual_o
);
  localparam int QW = $clog2(LVD_QUAL + 1);
  localparam logic [QW-1:0] QMAX = QW'(LVD_QUAL);

  logic [QW-1:0] run_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            run_q <= '0;
    else if (!lvd_i)        run_q <= '0;
    else if (run_q != QMAX) run_q <= run_q + QW'(1);
  end

  assign qual_o = (run_q == QMAX);

  p_qual_needs_run_r4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(qual_o) |-> $past(lvd_i));
endmodule

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic pin_low_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], pin_ni};
  end

  assign pin_low_o = !sync_q[STAGES-1];
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rst_seq_pkg::*;
#(
  parameter int CNT_W    = 13,
  parameter int HOLD_CYC = 4096,
  parameter int TAIL_CYC = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             lvd_qual_i,
  input  logic             wdog_rst_i,
  input  logic             pin_low_i,
  output logic             cnt_clr_o,
  output logic             pin_drive_o,
  output logic             cpu_rst_no,
  output logic             bus_clk_en_o,
  output rst_cause_t       cause_o
);
  localparam int TW = (TAIL_CYC > 1) ? $clog2(TAIL_CYC) : 1;
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
  localparam logic [TW-1:0]    TAIL_LAST = TW'(TAIL_CYC - 1);

  seq_state_e state_q, state_d;
  logic [TW-1:0] tail_q, tail_d;
  rst_cause_t cause_q, cause_d;
  logic bus_q, bus_d;
  logic int_req, hold_done;

  assign int_req   = lvd_qual_i | wdog_rst_i;
  assign hold_done = (cnt_i == HOLD_LAST);
  assign cnt_clr_o = int_req;

  always_comb begin
    state_d = state_q;
    tail_d  = tail_q;
    cause_d = cause_q;
    bus_d   = bus_q;
    if (int_req) begin
      state_d = ST_HOLD;
      cause_d = '0;
      if (lvd_qual_i) cause_d.lvd  = 1'b1;
      else            cause_d.wdog = 1'b1;
    end else begin
      unique case (state_q)
        ST_HOLD: if (hold_done) begin
          state_d = ST_TAIL;
          tail_d  = '0;
          bus_d   = 1'b1;
        end
        ST_TAIL: begin
          if (tail_q == TAIL_LAST) state_d = ST_RUN;
          else                     tail_d  = tail_q + TW'(1);
        end
        ST_RUN: if (pin_low_i) begin
          state_d = ST_PIN;
          cause_d = '0;
          cause_d.pin = 1'b1;
        end
        ST_PIN: if (!pin_low_i) begin
          state_d = ST_TAIL;
          tail_d  = '0;
        end
        default: state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      tail_q  <= '0;
      cause_q <= '{wdog: 1'b0, lvd: 1'b0, pin: 1'b0, por: 1'b1};
      bus_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tail_q  <= tail_d;
      cause_q <= cause_d;
      bus_q   <= bus_d;
    end
  end

  assign pin_drive_o  = (state_q == ST_HOLD);
  assign cpu_rst_no   = (state_q == ST_RUN);
  assign bus_clk_en_o = bus_q;
  assign cause_o      = cause_q;

  p_restart_r10: assert property (@(negedge clk_i) disable iff (!rst_ni)
    int_req |=> (pin_drive_o && !cpu_rst_no));
  p_release_after_tail_r3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rst_no) |-> ($past(state_q) == ST_TAIL));
  p_bus_sticky_r9: assert property (@(negedge clk_i) disable iff (!rst_ni)
    bus_clk_en_o |=> bus_clk_en_o);
  p_single_cause_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $countones(cause_q) == 1);
  p_pin_not_driven_r7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(cause_q.pin) |-> !pin_drive_o);
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top #(
  parameter int CNT_W    = 13,
  parameter int HOLD_CYC = 4096,
  parameter int TAIL_CYC = 64,
  parameter int LVD_QUAL = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvd_i,
  input  logic       wdog_rst_i,
  input  logic       pin_rst_ni,
  output logic       pin_rst_drive_o,
  output logic       cpu_rst_no,
  output logic       bus_clk_en_o,
  output logic       wdog_tick_o,
  output logic [3:0] rst_cause_o
);
  import rst_seq_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic cnt_clr, lvd_qual, pin_low;
  rst_cause_t cause;

  rst_prescaler #(.CNT_W(CNT_W)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .cnt_o (cnt),
    .tick_o(wdog_tick_o)
  );

  rst_lvd_filter #(.LVD_QUAL(LVD_QUAL)) u_lvd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvd_i (lvd_i),
    .qual_o(lvd_qual)
  );

  rst_pin_sync #(.STAGES(2)) u_pin (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_ni   (pin_rst_ni),
    .pin_low_o(pin_low)
  );

  rst_sequencer #(
    .CNT_W   (CNT_W),
    .HOLD_CYC(HOLD_CYC),
    .TAIL_CYC(TAIL_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_i       (cnt),
    .lvd_qual_i  (lvd_qual),
    .wdog_rst_i  (wdog_rst_i),
    .pin_low_i   (pin_low),
    .cnt_clr_o   (cnt_clr),
    .pin_drive_o (pin_rst_drive_o),
    .cpu_rst_no  (cpu_rst_no),
    .bus_clk_en_o(bus_clk_en_o),
    .cause_o     (cause)
  );

  assign rst_cause_o = cause;

  p_hold_span_r2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $fell(pin_rst_drive_o) |-> (cnt == CNT_W'(HOLD_CYC)));
  p_ext_keeps_count_r7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!cpu_rst_no && !pin_rst_drive_o && !cnt_clr) |=> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: tb/tb_rst_seq_top.sv
module tb_rst_seq_top;
  localparam int CNT_W = 6;
  localparam int HOLD  = 16;
  localparam int TAIL  = 4;
  localparam int QUAL  = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lvd = 1'b0, wdog = 1'b0, ext_low = 1'b0;
  logic drive, cpu_n, bus_en, tick;
  logic [3:0] cause;
  logic pin_n;
  int tests = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign pin_n = !(drive || ext_low);

  rst_seq_top #(.CNT_W(CNT_W), .HOLD_CYC(HOLD), .TAIL_CYC(TAIL), .LVD_QUAL(QUAL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .lvd_i(lvd), .wdog_rst_i(wdog), .pin_rst_ni(pin_n),
    .pin_rst_drive_o(drive), .cpu_rst_no(cpu_n), .bus_clk_en_o(bus_en),
    .wdog_tick_o(tick), .rst_cause_o(cause)
  );

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(output int h, output int t);
    h = 0; t = 0;
    while (drive && h < 1000) begin h++; step(1); end
    while (!cpu_n && t < 1000) begin t++; step(1); end
  endtask

  task automatic wait_tick(output int at);
    int n = 0;
    while (!tick && n < 500) begin n++; step(1); end
    at = cyc;
  endtask

  task automatic t_por;
    int h, t;
    step(3);
    check("R1 drive", drive, 1);
    check("R1 cpu", cpu_n, 0);
    check("R1 bus", bus_en, 0);
    check("R1 cause", cause, 4'b0001);
    rst_n = 1'b1;
    measure(h, t);
    check("R2 hold", h, HOLD);
    check("R3 tail", t, TAIL);
    check("R9 bus on", bus_en, 1);
  endtask

  task automatic t_tick;
    int a, b;
    wait_tick(a);
    step(1);
    check("R8 width", tick, 0);
    wait_tick(b);
    check("R8 period", b - a, 1 << CNT_W);
  endtask

  task automatic t_lvd_short;
    lvd = 1'b1; step(QUAL - 1); lvd = 1'b0;
    step(6);
    check("R4 short drive", drive, 0);
    check("R4 short cpu", cpu_n, 1);
    check("R4 short cause", cause, 4'b0001);
  endtask

  task automatic t_lvd_long;
    int h, t;
    lvd = 1'b1; step(QUAL); lvd = 1'b0;
    step(2);
    check("R4 long drive", drive, 1);
    check("R5 cause", cause, 4'b0100);
    measure(h, t);
    check("R3 tail lvd", t, TAIL);
    check("R4 back to run", cpu_n, 1);
  endtask

  task automatic t_wdog;
    int h, t;
    wdog = 1'b1; step(1); wdog = 1'b0;
    check("R6 drive", drive, 1);
    check("R6 cause", cause, 4'b1000);
    check("R9 bus kept", bus_en, 1);
    measure(h, t);
    check("R6 hold", h, HOLD);
    check("R3 tail wdog", t, TAIL);
  endtask

  task automatic t_restart;
    int h, t;
    wdog = 1'b1; step(1); wdog = 1'b0;
    step(5);
    wdog = 1'b1; step(1); wdog = 1'b0;
    measure(h, t);
    check("R10 hold restart", h, HOLD);
    wdog = 1'b1; step(1); wdog = 1'b0;
    h = 0;
    while (drive && h < 1000) begin h++; step(1); end
    check("R10 tail restart", h, HOLD);
    t = 0;
    while (!cpu_n && t < 1000) begin
      if (t == 2) begin wdog = 1'b1; step(1); wdog = 1'b0; break; end
      t++; step(1);
    end
    measure(h, t);
    check("R10 late tail restart", h, HOLD);
    check("R10 tail after", t, TAIL);
  endtask

  task automatic t_pin;
    int a, b, n;
    wait_tick(a);
    step(3);
    ext_low = 1'b1; step(5);
    check("R7 cpu held", cpu_n, 0);
    check("R7 no drive", drive, 0);
    check("R7 cause", cause, 4'b0010);
    ext_low = 1'b0;
    n = 0;
    while (!cpu_n && n < 100) begin n++; step(1); end
    check("R7 released", cpu_n, 1);
    wait_tick(b);
    check("R7 counter kept", b - a, 1 << CNT_W);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_por();
    t_tick();
    t_lvd_short();
    t_lvd_long();
    t_wdog();
    t_restart();
    t_pin();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule